// File: doc/BRIEF.md
# I2C memory transaction sequencer

This block turns one command (device address, internal address, byte count, direction) into the complete series of byte-level operations that a status-coded I2C master engine needs for a memory-style access. It starts each step by writing a control byte to the engine. It then waits for the engine's completion flag, compares the returned status code with the code that step should give, and either moves on or aborts. A separate engine drives the bus at bit level. This sequencer only orders the steps and checks their status codes.

A write sends the device address, then one to four internal address bytes, then the payload bytes taken from a valid/ready input stream. A read sends the same address phase as a dummy write. It then issues a repeated START with no STOP before it, sends the device address with the read bit set, and delivers the received bytes on a valid/ready output stream. A probe only checks that a device answers its read address. Every command finishes with STOP and a wait for the bus to go idle. A one-cycle `done` then presents a 32-bit result that is zero on success.

Back-pressure rules: `wr_ready` is high only while the sequencer needs the next payload byte, and a byte moves on any cycle where `wr_valid` and `wr_ready` are both high. `rd_valid` stays high with `rd_data` held steady until `rd_ready` is seen. While the byte waits, no further receive is started, so a slow consumer stalls the bus rather than losing data.

Top module: `i2c_mem_seq`

## Requirements
- R1: A `go` seen while idle latches the command and issues START, control 0x60, expecting status 0x08. Every control byte has the enable bit 6 set. Start is bit 5, stop is bit 4 and acknowledge is bit 2. The next byte is `{dev_addr, dir}`, where dir is 1 only for a probe or for the read phase. It expects 0x18 when dir is 0 and 0x40 when dir is 1. `op` is 00 for write, 01 for read and 1x for probe.
- R2: For a write or a read, `addr_len+1` internal address bytes of `mem_addr` follow the device byte, most significant byte first, and each one expects 0x28.
- R3: A read then issues a repeated START, control 0x60, expecting 0x10. No STOP comes in between. It then sends `{dev_addr,1}` expecting 0x40.
- R4: A read of N bytes issues N receives. The acknowledge bit is set on all of them except the last, and the expected status is 0x50 with acknowledge and 0x58 without. The bytes appear on `rd_data` in the order received and stay stable while `rd_ready` is low.
- R5: A write takes exactly `xfer_len` bytes from the write stream and sends each one expecting 0x28. With `xfer_len` 0, no byte is taken.
- R6: A probe sends `{dev_addr,1}`, performs one receive without acknowledge, discards the byte, and stops.
- R7: The first status that differs from the expected code ends the command. No further byte operation is issued, STOP follows, and the result is {8'h01, last control, actual status, expected status}.
- R8: If no completion flag arrives within TMO_TICKS pulses of `scl_tick`, the result is {8'h02, last control, current status, expected status}, and STOP follows.
- R9: Every command ends with STOP, control 0x50, then waits for status 0xF8. If 0xF8 does not appear within TMO_TICKS ticks, the result is {8'h02, 8'h50, current status, 8'hF8}, but only when no earlier error was recorded. Otherwise the earlier error is kept.
- R10: `done` is a one-cycle pulse that comes with `result`, and the result is 0 on success. `busy` is high from the cycle after `go` until `done`.
- R11: A `go` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| go | input | 1 | start a command when idle |
| op | input | 2 | 00 write, 01 read, 1x probe |
| dev_addr | input | 7 | target device address |
| mem_addr | input | MAX_ABYTES*8 | internal address |
| addr_len | input | IDX_W | internal address bytes minus one |
| xfer_len | input | LEN_W | payload byte count |
| busy | output | 1 | command in progress |
| done | output | 1 | one-cycle completion pulse |
| result | output | 32 | 0 or packed error word |
| wr_valid | input | 1 | write byte available |
| wr_ready | output | 1 | sequencer takes a write byte |
| wr_data | input | 8 | write byte |
| rd_valid | output | 1 | read byte available |
| rd_ready | input | 1 | consumer accepts read byte |
| rd_data | output | 8 | read byte |
| eng_cmd | output | 1 | one-cycle control write to the engine |
| eng_ctl | output | 8 | control byte; stays at the last value written |
| eng_wdata | output | 8 | byte to transmit |
| eng_done | input | 1 | engine completion flag pulse |
| eng_status | input | 8 | engine status code |
| eng_rdata | input | 8 | received byte |
| scl_tick | input | 1 | one pulse per bus clock period |

## Verification
The bench builds the block with MAX_ABYTES=4, so the four-byte address path and the wrap of the byte index are both reached. It sets LEN_W=8 and TMO_TICKS=8, with one `scl_tick` every four cycles. At that setting, both the completion-wait timeout and the idle-wait timeout expire within a few dozen cycles. A scripted engine model can then hang a chosen step, refuse to reach idle, or return a wrong start or address code. This lets the bench check both the order in which errors take priority and the fields packed into the error word.

// File: rtl/i2c_mem_seq_pkg.sv
package i2c_mem_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_WRGET, S_RDPUSH, S_STOP, S_IDLEWAIT
  } seq_state_e;

  typedef enum logic [2:0] {
    P_START, P_DEV, P_MADDR, P_RSTART, P_DEVR, P_RECV, P_WDATA
  } seq_phase_e;

  localparam logic [7:0] CTL_EN    = 8'h40;
  localparam logic [7:0] CTL_START = 8'h20;
  localparam logic [7:0] CTL_STOP  = 8'h10;
  localparam logic [7:0] CTL_ACK   = 8'h04;

  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_DW_ACK = 8'h28;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_DR_ACK = 8'h50;
  localparam logic [7:0] ST_DR_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  localparam logic [7:0] EC_STATUS = 8'h01;
  localparam logic [7:0] EC_TMO    = 8'h02;
endpackage

// File: rtl/i2c_mem_seq_abyte.sv
module i2c_mem_seq_abyte #(
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB*8-1:0] addr,
  input  logic [IW-1:0]   sel,
  output logic [7:0]      byte_o
);
  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = addr[g*8 +: 8];
  end

  assign byte_o = lanes[sel];
endmodule

// File: rtl/i2c_mem_seq_tmo.sv
module i2c_mem_seq_tmo #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (clear)                    cnt <= '0;
    else if (run && tick && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
  import i2c_mem_seq_pkg::*;
#(
  parameter int MAX_ABYTES = 4,
  parameter int LEN_W      = 16,
  parameter int TMO_TICKS  = 1000,
  localparam int IDX_W = (MAX_ABYTES > 1) ? $clog2(MAX_ABYTES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [1:0]              op,
  input  logic [6:0]              dev_addr,
  input  logic [MAX_ABYTES*8-1:0] mem_addr,
  input  logic [IDX_W-1:0]        addr_len,
  input  logic [LEN_W-1:0]        xfer_len,
  output logic                    busy,
  output logic                    done,
  output logic [31:0]             result,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [7:0]              rd_data,
  output logic                    eng_cmd,
  output logic [7:0]              eng_ctl,
  output logic [7:0]              eng_wdata,
  input  logic                    eng_done,
  input  logic [7:0]              eng_status,
  input  logic [7:0]              eng_rdata,
  input  logic                    scl_tick
);
  seq_state_e state, n_state;
  seq_phase_e phase, n_phase;

  logic [1:0]              op_q;
  logic [6:0]              dev_q;
  logic [MAX_ABYTES*8-1:0] addr_q;
  logic [IDX_W-1:0]        alen_q, idx, idx_nx, sel;
  logic [LEN_W-1:0]        rem;
  logic [7:0]              exp_st, n_ctl, n_data, n_exp, abyte;
  logic [31:0]             err_word, err_new, fin_word;
  logic                    err_hit, set_err, iss, cap_rd, dec_rem, idx_ld, fin, rx_ack;
  logic                    tmo_hit, is_probe, is_read;

  assign is_probe = op_q[1];
  assign is_read  = (op_q == 2'b01);
  assign busy     = (state != S_IDLE);
  assign wr_ready = (state == S_WRGET);
  assign sel      = (phase == P_DEV) ? alen_q : idx - IDX_W'(1);

  i2c_mem_seq_abyte #(.NB(MAX_ABYTES)) u_abyte (
    .addr(addr_q), .sel(sel), .byte_o(abyte)
  );

  i2c_mem_seq_tmo #(.LIMIT(TMO_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(iss),
    .run((state == S_WAIT) || (state == S_IDLEWAIT)),
    .tick(scl_tick), .expired(tmo_hit)
  );

  always_comb begin
    iss = 1'b0; n_ctl = CTL_EN; n_data = '0; n_exp = ST_IDLE;
    n_phase = phase; n_state = state; set_err = 1'b0; err_new = '0;
    cap_rd = 1'b0; dec_rem = 1'b0; idx_ld = 1'b0; idx_nx = idx;
    fin = 1'b0; fin_word = '0; rx_ack = 1'b0;
    case (state)
      S_IDLE: if (go) begin
        iss = 1'b1; n_ctl = CTL_EN | CTL_START; n_exp = ST_START;
        n_phase = P_START; n_state = S_WAIT;
      end
      S_WAIT: if (eng_done) begin
        if (eng_status != exp_st) begin
          set_err = 1'b1; err_new = {EC_STATUS, eng_ctl, eng_status, exp_st};
          n_state = S_STOP;
        end else begin
          case (phase)
            P_START: begin
              iss = 1'b1; n_data = {dev_q, is_probe};
              n_exp = is_probe ? ST_AR_ACK : ST_AW_ACK; n_phase = P_DEV;
            end
            P_DEV: if (is_probe) begin
              iss = 1'b1; n_exp = ST_DR_NAK; n_phase = P_RECV;
            end else begin
              iss = 1'b1; n_data = abyte; n_exp = ST_DW_ACK; n_phase = P_MADDR;
              idx_ld = 1'b1; idx_nx = alen_q;
            end
            P_MADDR: if (idx != '0) begin
              iss = 1'b1; n_data = abyte; n_exp = ST_DW_ACK;
              idx_ld = 1'b1; idx_nx = idx - IDX_W'(1);
            end else if (is_read) begin
              iss = 1'b1; n_ctl = CTL_EN | CTL_START; n_exp = ST_RSTART; n_phase = P_RSTART;
            end else begin
              n_state = (rem == '0) ? S_STOP : S_WRGET;
            end
            P_RSTART: begin
              iss = 1'b1; n_data = {dev_q, 1'b1}; n_exp = ST_AR_ACK; n_phase = P_DEVR;
            end
            P_DEVR: if (rem == '0) n_state = S_STOP;
            else begin
              rx_ack = (rem != LEN_W'(1));
              iss = 1'b1; n_ctl = CTL_EN | (rx_ack ? CTL_ACK : 8'h00);
              n_exp = rx_ack ? ST_DR_ACK : ST_DR_NAK; n_phase = P_RECV;
            end
            P_RECV: if (is_probe) n_state = S_STOP;
            else begin
              cap_rd = 1'b1; n_state = S_RDPUSH;
            end
            P_WDATA: begin
              dec_rem = 1'b1; n_state = (rem == LEN_W'(1)) ? S_STOP : S_WRGET;
            end
            default: n_state = S_STOP;
          endcase
        end
      end else if (tmo_hit) begin
        set_err = 1'b1; err_new = {EC_TMO, eng_ctl, eng_status, exp_st};
        n_state = S_STOP;
      end
      S_WRGET: if (wr_valid) begin
        iss = 1'b1; n_data = wr_data; n_exp = ST_DW_ACK; n_phase = P_WDATA; n_state = S_WAIT;
      end
      S_RDPUSH: if (rd_ready) begin
        dec_rem = 1'b1;
        if (rem == LEN_W'(1)) n_state = S_STOP;
        else begin
          rx_ack = (rem != LEN_W'(2));
          iss = 1'b1; n_ctl = CTL_EN | (rx_ack ? CTL_ACK : 8'h00);
          n_exp = rx_ack ? ST_DR_ACK : ST_DR_NAK; n_phase = P_RECV; n_state = S_WAIT;
        end
      end
      S_STOP: begin
        iss = 1'b1; n_ctl = CTL_EN | CTL_STOP; n_exp = ST_IDLE; n_state = S_IDLEWAIT;
      end
      S_IDLEWAIT: if ((eng_status == ST_IDLE) || tmo_hit) begin
        fin = 1'b1; n_state = S_IDLE;
        if (err_hit)                    fin_word = err_word;
        else if (eng_status != ST_IDLE) fin_word = {EC_TMO, eng_ctl, eng_status, ST_IDLE};
      end
      default: n_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= P_START; op_q <= '0; dev_q <= '0; addr_q <= '0;
      alen_q <= '0; idx <= '0; rem <= '0; exp_st <= '0; err_word <= '0; err_hit <= 1'b0;
      eng_cmd <= 1'b0; eng_ctl <= '0; eng_wdata <= '0; rd_valid <= 1'b0; rd_data <= '0;
      done <= 1'b0; result <= '0;
    end else begin
      state   <= n_state;
      phase   <= n_phase;
      eng_cmd <= iss;
      done    <= fin;
      if (iss) begin
        eng_ctl <= n_ctl; eng_wdata <= n_data; exp_st <= n_exp;
      end
      if (state == S_IDLE && go) begin
        op_q <= op; dev_q <= dev_addr; addr_q <= mem_addr; alen_q <= addr_len;
        rem <= xfer_len; err_hit <= 1'b0; err_word <= '0;
      end else if (dec_rem) begin
        rem <= rem - LEN_W'(1);
      end
      if (idx_ld)  idx <= idx_nx;
      if (set_err) begin
        err_hit <= 1'b1; err_word <= err_new;
      end
      if (cap_rd) begin
        rd_valid <= 1'b1; rd_data <= eng_rdata;
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
      end
      if (fin) result <= fin_word;
    end
  end
endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       eng_cmd,
  input logic [7:0] eng_ctl,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_enable_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd |-> eng_ctl[6]);

  assert_stop_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd && eng_ctl[4]) |-> (!eng_ctl[5] && !eng_ctl[2]));

  assert_wr_in_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !rd_valid));

  assert_go_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (eng_cmd && eng_ctl[5]));
endmodule

bind i2c_mem_seq i2c_mem_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .eng_cmd(eng_cmd),
  .eng_ctl(eng_ctl), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/i2c_mem_seq_test.sv
module i2c_mem_seq_test;
  logic        clk = 1'b0;
  logic        rst_n, go, wr_valid, rd_ready, eng_done, scl_tick;
  logic [1:0]  op;
  logic [6:0]  dev_addr;
  logic [31:0] mem_addr;
  logic [1:0]  addr_len;
  logic [7:0]  xfer_len, wr_data, eng_status, eng_rdata;
  logic        busy, done, wr_ready, rd_valid, eng_cmd;
  logic [31:0] result;
  logic [7:0]  rd_data, eng_ctl, eng_wdata;

  i2c_mem_seq #(.MAX_ABYTES(4), .LEN_W(8), .TMO_TICKS(8)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .dev_addr(dev_addr),
    .mem_addr(mem_addr), .addr_len(addr_len), .xfer_len(xfer_len),
    .busy(busy), .done(done), .result(result),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_cmd(eng_cmd), .eng_ctl(eng_ctl), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_status(eng_status), .eng_rdata(eng_rdata),
    .scl_tick(scl_tick)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, done_cnt = 0, wr_pops = 0, cyc = 0;
  int cmd_idx = 0, hang_at = -1, stop_cnt = 0, rs_cnt = 0, ack_cnt = 0, nak_cnt = 0, rptr = 0;
  bit stop_hang = 0, start_bad = 0, addr_nak = 0, bp = 0, wr_take = 0;
  bit in_x = 0, first = 0, rx_m = 0;
  logic [7:0]  wexp[$], rd_exp[$], wr_q[$];
  logic [31:0] res_exp[$];
  logic [7:0]  mc, md, mst;
  logic [31:0] tmp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic log_byte(input logic [7:0] b);
    if (wexp.size() == 0) chk("R2 unexpected sent byte", {24'h0, b}, 32'hFFFF_FFFF);
    else begin
      tmp = {24'h0, wexp.pop_front()};
      chk("R2/R5 sent byte", {24'h0, b}, tmp);
    end
  endtask

  // tick generator
  initial begin
    scl_tick = 1'b0;
    forever begin
      @(negedge clk); cyc++;
      scl_tick = (cyc % 4 == 0);
    end
  end

  // engine model
  initial begin
    eng_done = 1'b0; eng_status = 8'hF8; eng_rdata = 8'h00;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_cmd && rst_n) begin
        mc = eng_ctl; md = eng_wdata;
        if (mc[4]) begin
          stop_cnt++; in_x = 0; rx_m = 0; cmd_idx++;
          if (!stop_hang) begin
            repeat (3) @(negedge clk);
            eng_status = 8'hF8;
          end
        end else begin
          if (mc[5]) begin
            if (in_x) rs_cnt++;
            mst = start_bad ? 8'h38 : (in_x ? 8'h10 : 8'h08);
            in_x = 1; first = 1;
          end else if (first) begin
            log_byte(md); rx_m = md[0]; first = 0;
            mst = (md[0] && addr_nak) ? 8'h48 : (md[0] ? 8'h40 : 8'h18);
          end else if (rx_m) begin
            if (mc[2]) ack_cnt++; else nak_cnt++;
            eng_rdata = 8'h80 + 8'(rptr); rptr++;
            mst = mc[2] ? 8'h50 : 8'h58;
          end else begin
            log_byte(md); mst = 8'h28;
          end
          if (cmd_idx != hang_at) begin
            cmd_idx++;
            repeat (2) @(negedge clk);
            eng_status = mst; eng_done = 1'b1;
          end else cmd_idx++;
        end
      end
    end
  end

  // stream driver and monitor (scoreboard)
  initial begin
    rd_ready = 1'b0; wr_valid = 1'b0; wr_data = 8'h00;
    forever begin
      @(negedge clk);
      if (wr_take) begin
        void'(wr_q.pop_front()); wr_pops++; wr_take = 0;
      end
      wr_valid = (wr_q.size() > 0);
      wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
      if (wr_valid && wr_ready) wr_take = 1;
      rd_ready = bp ? (cyc % 3 == 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (rd_exp.size() == 0) chk("R4 unexpected read byte", {24'h0, rd_data}, 32'hFFFF_FFFF);
        else begin
          tmp = {24'h0, rd_exp.pop_front()};
          chk("R4 read byte order", {24'h0, rd_data}, tmp);
        end
      end
      if (done && rst_n) begin
        done_cnt++;
        if (res_exp.size() == 0) chk("R10 unexpected done", result, 32'hFFFF_FFFF);
        else begin
          tmp = res_exp.pop_front();
          chk("R7/R8/R9/R10 result word", result, tmp);
        end
      end
    end
  end

  task automatic prep();
    cmd_idx = 0; stop_cnt = 0; rs_cnt = 0; ack_cnt = 0; nak_cnt = 0; rptr = 0;
    hang_at = -1; stop_hang = 0; start_bad = 0; addr_nak = 0; bp = 0;
  endtask

  task automatic launch(input logic [1:0] o, input logic [6:0] dv, input logic [31:0] ma,
                        input logic [1:0] al, input logic [7:0] ln, input logic [31:0] er,
                        input bit spur);
    int d0;
    d0 = done_cnt;
    res_exp.push_back(er);
    op = o; dev_addr = dv; mem_addr = ma; addr_len = al; xfer_len = ln;
    go = 1'b1; @(negedge clk); go = 1'b0;
    if (spur) begin
      repeat (6) @(negedge clk);
      op = 2'b00; dev_addr = 7'h11; xfer_len = 8'd5;
      go = 1'b1; @(negedge clk); go = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; go = 1'b0; op = '0; dev_addr = '0; mem_addr = '0; addr_len = '0; xfer_len = '0;
    repeat (4) @(negedge clk);
    chk("R10 reset busy", {31'h0, busy}, 0);
    chk("R10 reset done", {31'h0, done}, 0);
    chk("R1 reset eng_cmd", {31'h0, eng_cmd}, 0);
    chk("R4 reset rd_valid", {31'h0, rd_valid}, 0);
    chk("R5 reset wr_ready", {31'h0, wr_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R5: write, two address bytes, three payload bytes
    prep();
    wexp = '{8'hA0, 8'h12, 8'h34, 8'hA1, 8'hB2, 8'hC3};
    wr_q = '{8'hA1, 8'hB2, 8'hC3};
    launch(2'b00, 7'h50, 32'h0000_1234, 2'd1, 8'd3, 32'h0, 0);
    chk("R2 all bytes sent", wexp.size(), 0);
    chk("R5 stream drained", wr_q.size(), 0);
    chk("R9 one stop", stop_cnt, 1);
    chk("R3 no restart on write", rs_cnt, 0);

    // R3 R4: read three bytes with back-pressure
    prep(); bp = 1;
    wexp = '{8'hA2, 8'h07, 8'hA3};
    rd_exp = '{8'h80, 8'h81, 8'h82};
    launch(2'b01, 7'h51, 32'h0000_0007, 2'd0, 8'd3, 32'h0, 0);
    chk("R3 one repeated start", rs_cnt, 1);
    chk("R3 single stop at end", stop_cnt, 1);
    chk("R4 acked receives", ack_cnt, 2);
    chk("R4 naked receives", nak_cnt, 1);
    chk("R4 all bytes delivered", rd_exp.size(), 0);

    // R2 R4: four-byte address, single byte read
    prep();
    wexp = '{8'h54, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h55};
    rd_exp = '{8'h80};
    launch(2'b01, 7'h2A, 32'hDEAD_BEEF, 2'd3, 8'd1, 32'h0, 0);
    chk("R2 four address bytes", wexp.size(), 0);
    chk("R4 single byte nak", nak_cnt, 1);
    chk("R4 single byte no ack", ack_cnt, 0);

    // R6: probe
    prep();
    wexp = '{8'h79};
    launch(2'b10, 7'h3C, 32'h0, 2'd0, 8'd0, 32'h0, 0);
    chk("R6 probe one nak receive", nak_cnt, 1);
    chk("R6 probe no byte delivered", {31'h0, rd_valid}, 0);
    chk("R6 probe stop", stop_cnt, 1);

    // R7: address not acknowledged in probe
    prep(); addr_nak = 1;
    wexp = '{8'h79};
    launch(2'b10, 7'h3C, 32'h0, 2'd0, 8'd0, 32'h0140_4840, 0);
    chk("R7 no receive after mismatch", nak_cnt + ack_cnt, 0);
    chk("R7 stop after mismatch", stop_cnt, 1);

    // R7: bad start status
    prep(); start_bad = 1;
    wexp.delete();
    launch(2'b00, 7'h50, 32'h12, 2'd0, 8'd1, 32'h0160_3808, 0);
    chk("R7 nothing after bad start", cmd_idx, 2);

    // R8: engine hangs on the first internal address byte
    prep(); hang_at = 2;
    wexp = '{8'hA0, 8'h12};
    launch(2'b00, 7'h50, 32'h0000_1234, 2'd1, 8'd1, 32'h0240_1828, 0);
    chk("R8 stop after timeout", stop_cnt, 1);

    // R9: idle never reached after clean write
    prep(); stop_hang = 1;
    wexp = '{8'hA0, 8'h05, 8'h66};
    wr_q = '{8'h66};
    launch(2'b00, 7'h50, 32'h05, 2'd0, 8'd1, 32'h0250_28F8, 0);

    // R9: earlier error kept over idle timeout
    prep(); stop_hang = 1; start_bad = 1;
    wexp.delete();
    launch(2'b00, 7'h50, 32'h05, 2'd0, 8'd1, 32'h0160_3808, 0);

    // R5: zero-length write takes no byte
    prep();
    wexp = '{8'hA0, 8'h09};
    wr_q = '{8'h77};
    begin
      int p0;
      p0 = wr_pops;
      launch(2'b00, 7'h50, 32'h09, 2'd0, 8'd0, 32'h0, 0);
      chk("R5 zero length takes nothing", wr_pops - p0, 0);
    end
    wr_q.delete();
    repeat (2) @(negedge clk);

    // R11: go while busy ignored
    prep();
    wexp = '{8'hA2, 8'h07, 8'hA3};
    rd_exp = '{8'h80, 8'h81};
    begin
      int d1, c1;
      d1 = done_cnt;
      launch(2'b01, 7'h51, 32'h07, 2'd0, 8'd2, 32'h0, 1);
      c1 = cmd_idx;
      repeat (15) @(negedge clk);
      chk("R11 single done", done_cnt - d1, 1);
      chk("R11 no extra engine command", cmd_idx, c1);
      chk("R11 idle after", {31'h0, busy}, 0);
      chk("R11 bytes of first command only", wexp.size(), 0);
    end

    chk("R10 all results seen", res_exp.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule